// File: doc/BRIEF.md
# Alternating Dual-Pipe Warp Issue Scheduler

This block picks which resident warp issues next inside one shader core. The core's execution units run on the fast clock. The scheduler makes one decision every second fast clock. Its decisions go in turn to the main arithmetic pipe (multiply-add and multiply) and to the special-function pipe (transcendentals and interpolation). Each pipe therefore gets a new warp every four fast clocks, and it must finish the warp it holds inside that window. Each warp shows the scheduler a ready flag and the class of its next operation. Each pipe has a stall input. For each decision the block emits a one-cycle issue strobe with the warp index, the target pipe and the operation class.

When a warp has just issued a multiply-add on the main pipe and its next operation is a multiply, the scheduler tries to place that multiply on the special-function pipe in the very next slot. The two operations then overlap. Mandatory special-function work always wins that slot, and so does a stalled special-function pipe. In either case the multiply is pushed back to the main pipe at its following slot, ahead of all other warps. Two counters report how often the offload worked and how often it fell back.

Top module: `ws_alt_scheduler`

## Requirements
- R1: After reset the first decision is made at the first rising clock edge and goes to the main pipe. Decisions then follow every second edge, alternating main, special-function, main, and so on. Each decision is registered: the issue outputs show it during the cycle after its decision edge, and issue_valid is never high in two consecutive cycles.
- R2: Operation classes are encoded on two bits: 0 multiply-add, 1 multiply, 2 transcendental, 3 interpolation. issue_pipe is 0 for the main pipe and 1 for the special-function pipe. The main pipe only receives classes 0 and 1. The special-function pipe only receives classes 2 and 3, plus class 1 when the multiply is offloaded (R6).
- R3: Among the warps eligible for a pipe, selection is round-robin. It starts at the warp after the last warp that pipe selected through its round-robin; after reset it starts at warp 0.
- R4: A warp whose ready flag is low at the decision edge is never issued.
- R5: A warp issued to one pipe is still in flight at the other pipe's next slot, so it is not eligible there. The offloaded multiply of R6 is the only exception.
- R6: Suppose the main pipe issues a multiply-add for warp w, and at the next special-function slot w is ready with class 1. If no mandatory work is eligible and that pipe is not stalled, w's multiply issues on the special-function pipe and dual_count increments by one.
- R7: An eligible transcendental or interpolation warp always takes the special-function slot ahead of a pending offloaded multiply.
- R8: If the multiply of R6 could not be offloaded, then at the next main slot it issues on the main pipe ahead of round-robin order, provided it is still ready and not stalled. fallback_count then increments by one.
- R9: While main_stall is high at a main decision edge, nothing issues to the main pipe. While sfu_stall is high at a special-function decision edge, nothing issues to that pipe.
- R10: During reset issue_valid is 0 and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Execution-unit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_ready | input | NUM_WARPS | Per-warp ready flag |
| warp_op | input | 2*NUM_WARPS | Per-warp next operation class, warp i at bits [2i+1:2i] |
| main_stall | input | 1 | Main pipe cannot accept a warp |
| sfu_stall | input | 1 | Special-function pipe is occupied |
| issue_valid | output | 1 | One-cycle issue strobe |
| issue_warp | output | $clog2(NUM_WARPS) | Issued warp index |
| issue_pipe | output | 1 | 0 main pipe, 1 special-function pipe |
| issue_op | output | 2 | Issued operation class |
| dual_count | output | CNT_W | Multiplies offloaded to the special-function pipe |
| fallback_count | output | CNT_W | Offload attempts returned to the main pipe |

## Verification
Each decision lands on a known edge: edge 1, 3, 5, ... after reset release, alternating between the main pipe and the special-function pipe. Its result and any counter increment become visible in the cycle after that edge. The bench drives inputs on falling edges. It then waits for one decision edge and checks the result on the next falling edge. It waits through the idle edge and confirms that the strobe has dropped before it sets up the next slot. Because of this, every expected warp index can be worked out slot by slot from the round-robin and priority rules.

// File: rtl/ws_sched_pkg.sv
package ws_sched_pkg;

  typedef enum logic [1:0] {
    OP_MAD    = 2'd0,
    OP_MUL    = 2'd1,
    OP_TRANS  = 2'd2,
    OP_INTERP = 2'd3
  } op_class_e;

  localparam logic PIPE_MAIN = 1'b0;
  localparam logic PIPE_SFU  = 1'b1;

endpackage

// File: rtl/ws_slot_timer.sv
module ws_slot_timer (
  input  logic clk,
  input  logic rst_n,
  output logic main_slot,
  output logic sfu_slot
);
  logic [1:0] phase_q;
  logic [1:0] phase_d;

  always_comb begin
    phase_d = phase_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 2'd0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign main_slot = (phase_q == 2'd0);
  assign sfu_slot  = (phase_q == 2'd2);
endmodule

// File: rtl/ws_rr_pick.sv
module ws_rr_pick #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = last;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (int'(last) + k) % N;
      if (!hit && req[c]) begin
        hit = 1'b1;
        idx = IW'(c);
      end
    end
  end
endmodule

// File: rtl/ws_event_counter.sv
module ws_event_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic [W-1:0] count_q;
  logic [W-1:0] count_d;

  always_comb begin
    count_d = count_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (inc) begin
      count_q <= count_d;
    end
  end

  assign count = count_q;
endmodule

// File: rtl/ws_alt_scheduler.sv
module ws_alt_scheduler
  import ws_sched_pkg::*;
#(
  parameter int NUM_WARPS = 32,
  parameter int CNT_W     = 16,
  localparam int IW       = $clog2(NUM_WARPS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_WARPS-1:0]   warp_ready,
  input  logic [2*NUM_WARPS-1:0] warp_op,
  input  logic                   main_stall,
  input  logic                   sfu_stall,
  output logic                   issue_valid,
  output logic [IW-1:0]          issue_warp,
  output logic                   issue_pipe,
  output logic [1:0]             issue_op,
  output logic [CNT_W-1:0]       dual_count,
  output logic [CNT_W-1:0]       fallback_count
);

  op_class_e op_arr [NUM_WARPS];

  for (genvar gi = 0; gi < NUM_WARPS; gi++) begin : g_op
    assign op_arr[gi] = op_class_e'(warp_op[2*gi +: 2]);
  end

  // Slot timing
  logic main_slot, sfu_slot;

  ws_slot_timer i_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .main_slot (main_slot),
    .sfu_slot  (sfu_slot)
  );

  // Pipe occupancy and offload tracking
  logic          main_own_vld_q, sfu_own_vld_q;
  logic [IW-1:0] main_own_q, sfu_own_q;
  logic [IW-1:0] main_last_q, sfu_last_q;
  logic          chain_vld_q, fb_vld_q;
  logic [IW-1:0] chain_q, fb_q;

  logic          main_own_vld_d, sfu_own_vld_d;
  logic [IW-1:0] main_own_d, sfu_own_d;
  logic [IW-1:0] main_last_d, sfu_last_d;
  logic          chain_vld_d, fb_vld_d;
  logic [IW-1:0] chain_d, fb_d;
  logic          state_en;

  // Eligibility
  logic [NUM_WARPS-1:0] main_req, mand_req;

  always_comb begin
    for (int i = 0; i < NUM_WARPS; i++) begin
      main_req[i] = warp_ready[i] &&
                    (op_arr[i] == OP_MAD || op_arr[i] == OP_MUL) &&
                    !(sfu_own_vld_q && sfu_own_q == IW'(i));
      mand_req[i] = warp_ready[i] &&
                    (op_arr[i] == OP_TRANS || op_arr[i] == OP_INTERP) &&
                    !(main_own_vld_q && main_own_q == IW'(i));
    end
  end

  logic          main_hit, mand_hit;
  logic [IW-1:0] main_idx, mand_idx;

  ws_rr_pick #(.N(NUM_WARPS), .IW(IW)) i_pick_main (
    .req  (main_req),
    .last (main_last_q),
    .hit  (main_hit),
    .idx  (main_idx)
  );

  ws_rr_pick #(.N(NUM_WARPS), .IW(IW)) i_pick_sfu (
    .req  (mand_req),
    .last (sfu_last_q),
    .hit  (mand_hit),
    .idx  (mand_idx)
  );

  // Slot decisions
  logic          chain_ok, fb_hit;
  logic          m_vld, s_mand, s_chain, s_vld;
  logic [IW-1:0] m_idx, s_idx;

  always_comb begin
    chain_ok = chain_vld_q && warp_ready[chain_q] && (op_arr[chain_q] == OP_MUL);
    fb_hit   = fb_vld_q && main_req[fb_q] && (op_arr[fb_q] == OP_MUL);
    m_vld    = !main_stall && (fb_hit || main_hit);
    m_idx    = fb_hit ? fb_q : main_idx;
    s_mand   = !sfu_stall && mand_hit;
    s_chain  = !sfu_stall && !mand_hit && chain_ok;
    s_vld    = s_mand || s_chain;
    s_idx    = s_mand ? mand_idx : chain_q;
  end

  // Next state
  always_comb begin
    main_own_vld_d = main_own_vld_q;
    main_own_d     = main_own_q;
    main_last_d    = main_last_q;
    sfu_own_vld_d  = sfu_own_vld_q;
    sfu_own_d      = sfu_own_q;
    sfu_last_d     = sfu_last_q;
    chain_vld_d    = chain_vld_q;
    chain_d        = chain_q;
    fb_vld_d       = fb_vld_q;
    fb_d           = fb_q;
    state_en       = main_slot || sfu_slot;
    if (main_slot) begin
      main_own_vld_d = m_vld;
      main_own_d     = m_idx;
      if (m_vld) main_last_d = m_idx;
      chain_vld_d    = m_vld && (op_arr[m_idx] == OP_MAD);
      chain_d        = m_idx;
      fb_vld_d       = 1'b0;
    end else if (sfu_slot) begin
      sfu_own_vld_d  = s_vld;
      sfu_own_d      = s_idx;
      if (s_mand) sfu_last_d = mand_idx;
      chain_vld_d    = 1'b0;
      fb_vld_d       = chain_ok && !s_chain;
      fb_d           = chain_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_own_vld_q <= 1'b0;
      main_own_q     <= '0;
      main_last_q    <= IW'(NUM_WARPS - 1);
      sfu_own_vld_q  <= 1'b0;
      sfu_own_q      <= '0;
      sfu_last_q     <= IW'(NUM_WARPS - 1);
      chain_vld_q    <= 1'b0;
      chain_q        <= '0;
      fb_vld_q       <= 1'b0;
      fb_q           <= '0;
    end else if (state_en) begin
      main_own_vld_q <= main_own_vld_d;
      main_own_q     <= main_own_d;
      main_last_q    <= main_last_d;
      sfu_own_vld_q  <= sfu_own_vld_d;
      sfu_own_q      <= sfu_own_d;
      sfu_last_q     <= sfu_last_d;
      chain_vld_q    <= chain_vld_d;
      chain_q        <= chain_d;
      fb_vld_q       <= fb_vld_d;
      fb_q           <= fb_d;
    end
  end

  // Issue output register
  logic          vld_d, pipe_d;
  logic [IW-1:0] warp_d;
  logic [1:0]    op_d;

  always_comb begin
    vld_d  = (main_slot && m_vld) || (sfu_slot && s_vld);
    warp_d = main_slot ? m_idx : s_idx;
    pipe_d = main_slot ? PIPE_MAIN : PIPE_SFU;
    op_d   = op_arr[warp_d];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_valid <= 1'b0;
      issue_warp  <= '0;
      issue_pipe  <= PIPE_MAIN;
      issue_op    <= 2'd0;
    end else begin
      issue_valid <= vld_d;
      issue_warp  <= warp_d;
      issue_pipe  <= pipe_d;
      issue_op    <= op_d;
    end
  end

  // Offload statistics
  ws_event_counter #(.W(CNT_W)) i_dual_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (sfu_slot && s_chain),
    .count (dual_count)
  );

  ws_event_counter #(.W(CNT_W)) i_fb_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (main_slot && !main_stall && fb_hit),
    .count (fallback_count)
  );

endmodule

// File: rtl/ws_alt_scheduler_chk.sv
module ws_alt_scheduler_chk
  import ws_sched_pkg::*;
#(
  parameter int NUM_WARPS = 32,
  parameter int CNT_W     = 16,
  localparam int IW       = $clog2(NUM_WARPS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_WARPS-1:0] warp_ready,
  input logic                 main_stall,
  input logic                 sfu_stall,
  input logic                 issue_valid,
  input logic [IW-1:0]        issue_warp,
  input logic                 issue_pipe,
  input logic [1:0]           issue_op,
  input logic [CNT_W-1:0]     dual_count,
  input logic [CNT_W-1:0]     fallback_count
);
  logic [NUM_WARPS-1:0] ready_q;

  always_ff @(posedge clk) begin
    ready_q <= warp_ready;
  end

  p_strobe_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> !issue_valid);

  p_main_then_sfu_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_pipe == PIPE_MAIN) |=> ##1 (!issue_valid || issue_pipe == PIPE_SFU));

  p_sfu_then_main_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_pipe == PIPE_SFU) |=> ##1 (!issue_valid || issue_pipe == PIPE_MAIN));

  p_main_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_pipe == PIPE_MAIN) |-> (issue_op == 2'd0 || issue_op == 2'd1));

  p_sfu_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_pipe == PIPE_SFU) |-> (issue_op != 2'd0));

  p_ready_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> ready_q[issue_warp]);

  p_sfu_inflight_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_pipe == PIPE_SFU) |=> ##1 !(issue_valid && issue_warp == $past(issue_warp, 2)));

  p_dual_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dual_count != $past(dual_count)) |->
      (dual_count == $past(dual_count) + CNT_W'(1) && issue_valid &&
       issue_pipe == PIPE_SFU && issue_op == 2'd1));

  p_fallback_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fallback_count != $past(fallback_count)) |->
      (fallback_count == $past(fallback_count) + CNT_W'(1) && issue_valid &&
       issue_pipe == PIPE_MAIN && issue_op == 2'd1));

  p_main_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_pipe == PIPE_MAIN) |-> !$past(main_stall));

  p_sfu_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_pipe == PIPE_SFU) |-> !$past(sfu_stall));

endmodule

bind ws_alt_scheduler ws_alt_scheduler_chk #(
  .NUM_WARPS (NUM_WARPS),
  .CNT_W     (CNT_W)
) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .warp_ready     (warp_ready),
  .main_stall     (main_stall),
  .sfu_stall      (sfu_stall),
  .issue_valid    (issue_valid),
  .issue_warp     (issue_warp),
  .issue_pipe     (issue_pipe),
  .issue_op       (issue_op),
  .dual_count     (dual_count),
  .fallback_count (fallback_count)
);

// File: tb/test_ws_alt_scheduler.sv
`timescale 1ns/1ps
module test_ws_alt_scheduler;
  localparam int N  = 4;
  localparam int CW = 8;
  localparam logic [1:0] MAD = 2'd0, MUL = 2'd1, TRN = 2'd2, INT = 2'd3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  warp_ready = '0;
  logic [2*N-1:0] warp_op = '0;
  logic          main_stall = 1'b0, sfu_stall = 1'b0;
  logic          issue_valid, issue_pipe;
  logic [1:0]    issue_warp;
  logic [1:0]    issue_op;
  logic [CW-1:0] dual_count, fallback_count;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  ws_alt_scheduler #(.NUM_WARPS(N), .CNT_W(CW)) i_ws_alt_scheduler (
    .clk            (clk),
    .rst_n          (rst_n),
    .warp_ready     (warp_ready),
    .warp_op        (warp_op),
    .main_stall     (main_stall),
    .sfu_stall      (sfu_stall),
    .issue_valid    (issue_valid),
    .issue_warp     (issue_warp),
    .issue_pipe     (issue_pipe),
    .issue_op       (issue_op),
    .dual_count     (dual_count),
    .fallback_count (fallback_count)
  );

  task automatic set_ops(input logic [1:0] o0, o1, o2, o3);
    warp_op = {o3, o2, o1, o0};
  endtask

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One scheduler slot: decision edge, check, idle edge, check strobe low.
  task automatic slot(input string req, input bit ev, input int ew, input bit ep, input logic [1:0] eo);
    @(posedge clk); @(negedge clk);
    chk(req, int'(issue_valid), int'(ev), "issue_valid");
    if (ev) begin
      chk(req, int'(issue_warp), ew, "issue_warp");
      chk(req, int'(issue_pipe), int'(ep), "issue_pipe");
      chk(req, int'(issue_op), int'(eo), "issue_op");
    end
    @(posedge clk); @(negedge clk);
    chk("R1", int'(issue_valid), 0, "strobe on idle cycle");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    main_stall = 1'b0;
    sfu_stall  = 1'b0;
    warp_ready = '0;
    warp_op    = '0;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    // R10 reset state
    do_reset();
    chk("R10", int'(issue_valid), 0, "valid in reset");
    chk("R10", int'(dual_count), 0, "dual_count in reset");
    chk("R10", int'(fallback_count), 0, "fallback_count in reset");

    // R3 main round-robin, R1 alternation (sfu slots idle, no mandatory work)
    warp_ready = 4'b1111; set_ops(MAD, MAD, MAD, MAD); rst_n = 1'b1;
    slot("R3", 1, 0, 0, MAD);
    slot("R1", 0, 0, 1, MAD);
    slot("R3", 1, 1, 0, MAD);
    slot("R1", 0, 0, 1, MAD);
    slot("R3", 1, 2, 0, MAD);
    slot("R1", 0, 0, 1, MAD);
    slot("R3", 1, 3, 0, MAD);
    slot("R1", 0, 0, 1, MAD);
    slot("R3", 1, 0, 0, MAD);

    // R4 not-ready warp skipped
    do_reset();
    warp_ready = 4'b1101; set_ops(MAD, MAD, MAD, MAD); rst_n = 1'b1;
    slot("R4", 1, 0, 0, MAD);
    slot("R4", 0, 0, 1, MAD);
    slot("R4", 1, 2, 0, MAD);
    slot("R4", 0, 0, 1, MAD);
    slot("R4", 1, 3, 0, MAD);
    slot("R4", 0, 0, 1, MAD);
    slot("R4", 1, 0, 0, MAD);

    // R2/R3 mixed classes: each pipe round-robins its own class
    do_reset();
    warp_ready = 4'b1111; set_ops(TRN, INT, MAD, MAD); rst_n = 1'b1;
    slot("R2", 1, 2, 0, MAD);
    slot("R2", 1, 0, 1, TRN);
    slot("R3", 1, 3, 0, MAD);
    slot("R3", 1, 1, 1, INT);
    slot("R3", 1, 2, 0, MAD);
    slot("R3", 1, 0, 1, TRN);

    // R6 offloaded multiply, then R5 exclusion of the sfu-held warp
    do_reset();
    warp_ready = 4'b0001; set_ops(MAD, MAD, MAD, MAD); rst_n = 1'b1;
    slot("R6", 1, 0, 0, MAD);
    set_ops(MUL, MAD, MAD, MAD);
    slot("R6", 1, 0, 1, MUL);
    chk("R6", int'(dual_count), 1, "dual_count");
    slot("R5", 0, 0, 0, MUL);
    slot("R5", 0, 0, 1, MUL);
    slot("R5", 1, 0, 0, MUL);
    chk("R8", int'(fallback_count), 0, "no fallback after offload");

    // R5 main-held warp not eligible at next sfu slot
    do_reset();
    warp_ready = 4'b0001; set_ops(MAD, MAD, MAD, MAD); rst_n = 1'b1;
    slot("R5", 1, 0, 0, MAD);
    set_ops(TRN, MAD, MAD, MAD);
    slot("R5", 0, 0, 1, TRN);
    slot("R5", 0, 0, 0, TRN);
    slot("R5", 1, 0, 1, TRN);

    // R7 mandatory work wins; R8 multiply falls back to main
    do_reset();
    warp_ready = 4'b0011; set_ops(MAD, TRN, MAD, MAD); rst_n = 1'b1;
    slot("R7", 1, 0, 0, MAD);
    set_ops(MUL, TRN, MAD, MAD);
    slot("R7", 1, 1, 1, TRN);
    slot("R8", 1, 0, 0, MUL);
    chk("R8", int'(fallback_count), 1, "fallback_count");
    chk("R6", int'(dual_count), 0, "dual_count with mandatory work");

    // R9 sfu stall blocks both mandatory and offload; R8 fallback priority
    do_reset();
    warp_ready = 4'b0111; set_ops(MAD, TRN, MAD, MAD); rst_n = 1'b1;
    slot("R9", 1, 0, 0, MAD);
    set_ops(MUL, TRN, MAD, MAD); sfu_stall = 1'b1;
    slot("R9", 0, 0, 1, MUL);
    sfu_stall = 1'b0;
    slot("R8", 1, 0, 0, MUL);
    chk("R8", int'(fallback_count), 1, "fallback after stall");
    slot("R9", 1, 1, 1, TRN);
    slot("R3", 1, 2, 0, MAD);

    // R9 main stall
    do_reset();
    warp_ready = 4'b0001; set_ops(MAD, MAD, MAD, MAD); main_stall = 1'b1; rst_n = 1'b1;
    slot("R9", 0, 0, 0, MAD);
    slot("R9", 0, 0, 1, MAD);
    main_stall = 1'b0;
    slot("R9", 1, 0, 0, MAD);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule